// File: doc/BRIEF.md
# External Interrupt Sensitivity Detector

This block turns a set of external pins into interrupt pending flags, one flag per source. Each source has its own three-bit sensitivity code. The code selects one of these triggers: a falling edge, a rising edge, either edge, a falling edge together with a low level, or a rising edge together with a high level. The last of these is available only on the sources named by a parameter. The pins are asynchronous and pass through a two-flop synchroniser. An edge is found by comparing the synchronised value with the value it held one cycle earlier.

Software writes a sensitivity code through a simple write strobe with a source index. The write takes effect only while the CPU priority input is at its highest mask level. If a write changes a source's code, that source's pending flag is dropped. Software clears flags with a per-source clear pulse. A per-source "port pin low" input shows that another pin on the same vector is being held at ground. While that input is high, the source is masked: its flag is forced to zero and events are thrown away. The flags go to the interrupt controller, and the current codes can be read back.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every pending flag is 0 and every sensitivity code reads 0. Code 0 means falling edge.
- R2: Code 0 sets the flag on a synchronised 1-to-0 transition of the pin, three rising clock edges after the pin changes. The flag then stays set until software clears it, and a 0-to-1 transition does not set it.
- R3: Code 1 sets the flag on a 0-to-1 transition only.
- R4: Code 2 sets the flag on a transition in either direction.
- R5: Code 3 sets the flag on a falling edge and keeps setting it while the synchronised pin is low, so a clear pulse has no effect while the pin is low.
- R6: On sources enabled by `HILVL_MASK` (sources 0 and 2 by default), code 4 sets the flag on a rising edge and keeps setting it while the synchronised pin is high.
- R7: Code 4 on any other source, and codes 5 to 7 on any source, behave as code 3.
- R8: An accepted write whose value differs from the stored code stores the new code and clears that source's flag on the same clock edge. The clear takes precedence over a trigger in that cycle.
- R9: An accepted write of the value already stored leaves the flag unchanged.
- R10: A write is accepted only when `cpu_lvl_i` is 2'b11. Any other level leaves the code and the flag untouched.
- R11: While `port_low_i` for a source is 1, its flag is 0 from the next clock edge onward, and triggers during that time are discarded.
- R12: A clear pulse drops a flag on the next edge, unless a trigger occurs in the same cycle, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_SRC | Asynchronous external pins, one per source |
| cpu_lvl_i | input | 2 | Current CPU interrupt mask level; 2'b11 enables code writes |
| sens_we_i | input | 1 | Sensitivity code write strobe |
| sens_sel_i | input | SEL_W | Source index of the write |
| sens_val_i | input | 3 | Sensitivity code to write |
| pend_clr_i | input | NUM_SRC | Per-source pending clear pulse |
| port_low_i | input | NUM_SRC | Per-source mask: a shared port pin is forced low |
| pend_o | output | NUM_SRC | Pending request per source |
| sens_o | output | 3*NUM_SRC | Stored codes, source i at bits [3i+2:3i] |

## Verification
A pin change that is driven between edges reaches `pend_o` on the third rising edge: two edges go through the synchroniser and one through the flag register. A write, a clear or a mask acts on `pend_o` and `sens_o` at the first rising edge. The bench drives all inputs on falling edges and keeps a behavioural model that advances on every rising edge. On every falling edge it compares both outputs with the model. The directed checks wait exactly those edge counts, checking the flag one edge before it is due and again on the edge it is due.

// File: rtl/eis_pkg.sv
// Package for the external interrupt sensitivity detector.
// Holds the sensitivity code width, the trigger enumeration and the decode
// that folds unsupported codes onto falling edge with low level.
package eis_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        SNS_FALL    = 3'd0,
        SNS_RISE    = 3'd1,
        SNS_BOTH    = 3'd2,
        SNS_FALL_LO = 3'd3,
        SNS_RISE_HI = 3'd4
    } sns_e;

    // Map a stored code to the trigger actually used by a source.
    function automatic sns_e eff_mode(input logic [MODE_W-1:0] code, input logic hi_ok);
        case (code)
            3'd0:    return SNS_FALL;
            3'd1:    return SNS_RISE;
            3'd2:    return SNS_BOTH;
            3'd3:    return SNS_FALL_LO;
            3'd4:    return hi_ok ? SNS_RISE_HI : SNS_FALL_LO;
            default: return SNS_FALL_LO;
        endcase
    endfunction
endpackage

// File: rtl/eis_sync.sv
// Two-flop synchroniser plus one history flop per bit.
// Assumes inputs are asynchronous and idle at RST_VAL.
// cur_o is the synchronised value; prev_o is cur_o one cycle earlier.
module eis_sync #(
    parameter int   W       = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;

    // Shift the pins through the two stages and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            cur_o  <= {W{RST_VAL}};
            prev_o <= {W{RST_VAL}};
        end else begin
            meta_q <= d_i;
            cur_o  <= meta_q;
            prev_o <= cur_o;
        end
    end
endmodule

// File: rtl/eis_cfg.sv
// Sensitivity code registers with the priority-level write gate.
// A write is taken only when both level bits are 1. chg_o pulses for a
// source whose accepted write carries a value different from the stored one.
module eis_cfg
    import eis_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [SEL_W-1:0]               sel_i,
    input  logic [MODE_W-1:0]              val_i,
    input  logic [1:0]                     lvl_i,
    output logic [NUM_SRC-1:0][MODE_W-1:0] code_o,
    output logic [NUM_SRC-1:0]             chg_o
);
    logic lvl_top;
    assign lvl_top = &lvl_i;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fld
        logic hit;
        assign hit      = we_i && lvl_top && (sel_i == SEL_W'(g));
        assign chg_o[g] = hit && (val_i != code_o[g]);

        // Store the new code only when it changes the field.
        always_ff @(posedge clk) begin
            if (!rst_n)        code_o[g] <= '0;
            else if (chg_o[g]) code_o[g] <= val_i;
        end
    end

    // R10
    lvl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_top |=> $stable(code_o));
endmodule

// File: rtl/eis_detect.sv
// Trigger decode and pending flag for one source.
// Assumes cur_i/prev_i come from the synchroniser. Priority of the next flag
// value: mask, then code change, then trigger, then software clear.
module eis_detect
    import eis_pkg::*;
#(
    parameter logic HI_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] code_i,
    input  logic              cur_i,
    input  logic              prev_i,
    input  logic              mask_i,
    input  logic              cfg_clr_i,
    input  logic              sw_clr_i,
    output logic              pend_o
);
    sns_e mode;
    logic rise, fall, trig;

    // Decode the trigger condition for the active mode.
    always_comb begin
        mode = eff_mode(code_i, HI_OK);
        rise = cur_i & ~prev_i;
        fall = ~cur_i & prev_i;
        case (mode)
            SNS_FALL:    trig = fall;
            SNS_RISE:    trig = rise;
            SNS_BOTH:    trig = rise | fall;
            SNS_RISE_HI: trig = rise | cur_i;
            default:     trig = fall | ~cur_i;
        endcase
    end

    // Update the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend_o <= 1'b0;
        else if (mask_i || cfg_clr_i) pend_o <= 1'b0;
        else                          pend_o <= trig | (pend_o & ~sw_clr_i);
    end

    // R11
    mask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> !pend_o);
    // R2
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !sw_clr_i && !mask_i && !cfg_clr_i) |=> pend_o);
    // R5
    low_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SNS_FALL_LO && !cur_i && !mask_i && !cfg_clr_i) |=> pend_o);
    // R6
    high_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SNS_RISE_HI && cur_i && !mask_i && !cfg_clr_i) |=> pend_o);
    // R12
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && mode == SNS_RISE && sw_clr_i && !mask_i && !cfg_clr_i) |=> pend_o);
endmodule

// File: rtl/ext_irq_sense.sv
// External interrupt sensitivity detector, top level.
// Synchronises the pins, holds one sensitivity code per source and produces
// one pending request per source. HILVL_MASK bit i enables the rising edge
// with high level mode on source i. Pins are assumed idle high.
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int           NUM_SRC    = 4,
    parameter logic [NUM_SRC-1:0] HILVL_MASK = 4'b0101,
    localparam int          SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        pin_i,
    input  logic [1:0]                cpu_lvl_i,
    input  logic                      sens_we_i,
    input  logic [SEL_W-1:0]          sens_sel_i,
    input  logic [MODE_W-1:0]         sens_val_i,
    input  logic [NUM_SRC-1:0]        pend_clr_i,
    input  logic [NUM_SRC-1:0]        port_low_i,
    output logic [NUM_SRC-1:0]        pend_o,
    output logic [NUM_SRC*MODE_W-1:0] sens_o
);
    logic [NUM_SRC-1:0]             s_cur, s_prev, chg;
    logic [NUM_SRC-1:0][MODE_W-1:0] codes;

    eis_sync #(.W(NUM_SRC), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .cur_o(s_cur), .prev_o(s_prev)
    );

    eis_cfg #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(sens_we_i), .sel_i(sens_sel_i),
        .val_i(sens_val_i), .lvl_i(cpu_lvl_i), .code_o(codes), .chg_o(chg)
    );

    assign sens_o = codes;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        eis_detect #(.HI_OK(HILVL_MASK[g])) u_det (
            .clk(clk), .rst_n(rst_n), .code_i(codes[g]),
            .cur_i(s_cur[g]), .prev_i(s_prev[g]), .mask_i(port_low_i[g]),
            .cfg_clr_i(chg[g]), .sw_clr_i(pend_clr_i[g]), .pend_o(pend_o[g])
        );

        // R8
        code_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sens_we_i && (&cpu_lvl_i) && sens_sel_i == SEL_W'(g)
             && sens_val_i != sens_o[g*MODE_W +: MODE_W]) |=> !pend_o[g]);
    end
endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '1;
    logic [1:0]   lvl = 2'b11;
    logic         we = 1'b0;
    logic [1:0]   sel = '0;
    logic [2:0]   val = '0;
    logic [N-1:0] clr = '0;
    logic [N-1:0] plo = '0;
    logic [N-1:0] pend;
    logic [3*N-1:0] sens;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural model state
    int m_s1[N], m_s2[N], m_prev[N], m_cfg[N], m_pend[N];

    always #5 clk = ~clk;

    ext_irq_sense u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cpu_lvl_i(lvl),
        .sens_we_i(we), .sens_sel_i(sel), .sens_val_i(val),
        .pend_clr_i(clr), .port_low_i(plo), .pend_o(pend), .sens_o(sens)
    );

    // Reference model: advance one step per rising edge from the requirements.
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            int md, rise, fall, trig, chg;
            if (!rst_n) begin
                m_s1[i] = 1; m_s2[i] = 1; m_prev[i] = 1; m_cfg[i] = 0; m_pend[i] = 0;
            end else begin
                md = m_cfg[i];
                if (md == 4 && !(i == 0 || i == 2)) md = 3;
                if (md > 4) md = 3;
                rise = (m_s2[i] == 1 && m_prev[i] == 0);
                fall = (m_s2[i] == 0 && m_prev[i] == 1);
                case (md)
                    0: trig = fall;
                    1: trig = rise;
                    2: trig = rise || fall;
                    3: trig = fall || (m_s2[i] == 0);
                    default: trig = rise || (m_s2[i] == 1);
                endcase
                chg = (we && lvl == 2'b11 && int'(sel) == i && int'(val) != m_cfg[i]);
                if (plo[i] || chg) m_pend[i] = 0;
                else m_pend[i] = (trig || (m_pend[i] && !clr[i])) ? 1 : 0;
                if (chg) m_cfg[i] = int'(val);
                m_prev[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = int'(pin[i]);
            end
        end
    end

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < N; i++) begin
                checks++;
                if (int'(pend[i]) != m_pend[i]) begin
                    errors++;
                    $display("FAIL %s model pend[%0d] actual %0d expected %0d", cur_req, i, pend[i], m_pend[i]);
                end
                checks++;
                if (int'(sens[3*i +: 3]) != m_cfg[i]) begin
                    errors++;
                    $display("FAIL %s model code[%0d] actual %0d expected %0d", cur_req, i, sens[3*i +: 3], m_cfg[i]);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input int v, input logic [1:0] l);
        lvl = l; we = 1'b1; sel = 2'(s); val = 3'(v);
        cyc(1);
        we = 1'b0; lvl = 2'b11;
    endtask

    task automatic pulse_clr(input logic [N-1:0] m);
        clr = m;
        cyc(1);
        clr = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        cur_req = "R1";
        chk("R1 pend after reset", int'(pend), 0);
        chk("R1 codes after reset", int'(sens), 0);

        cur_req = "R2";
        pin[0] = 1'b0; cyc(2);
        chk("R2 fall not yet", int'(pend[0]), 0);
        cyc(1);
        chk("R2 fall set", int'(pend[0]), 1);
        cyc(5);
        chk("R2 sticky", int'(pend[0]), 1);
        pulse_clr(4'b0001);
        chk("R2 cleared", int'(pend[0]), 0);
        pin[0] = 1'b1; cyc(4);
        chk("R2 rise ignored", int'(pend[0]), 0);

        cur_req = "R3";
        wr(1, 1, 2'b11);
        pin[1] = 1'b0; cyc(4);
        chk("R3 fall ignored", int'(pend[1]), 0);
        pin[1] = 1'b1; cyc(3);
        chk("R3 rise set", int'(pend[1]), 1);
        pulse_clr(4'b0010);

        cur_req = "R4";
        wr(2, 2, 2'b11);
        pin[2] = 1'b0; cyc(3);
        chk("R4 fall set", int'(pend[2]), 1);
        pulse_clr(4'b0100);
        pin[2] = 1'b1; cyc(3);
        chk("R4 rise set", int'(pend[2]), 1);
        pulse_clr(4'b0100);

        cur_req = "R5";
        wr(3, 3, 2'b11);
        pin[3] = 1'b0; cyc(3);
        chk("R5 low set", int'(pend[3]), 1);
        pulse_clr(4'b1000);
        chk("R5 clear ignored while low", int'(pend[3]), 1);
        pin[3] = 1'b1; cyc(3);
        pulse_clr(4'b1000);
        chk("R5 clear after high", int'(pend[3]), 0);

        cur_req = "R6";
        wr(0, 4, 2'b11);
        cyc(1);
        chk("R6 high level set", int'(pend[0]), 1);
        pin[0] = 1'b0; cyc(2);
        pulse_clr(4'b0001);
        chk("R6 clear when low", int'(pend[0]), 0);
        pin[0] = 1'b1; cyc(3);
        chk("R6 rise set", int'(pend[0]), 1);

        cur_req = "R7";
        wr(1, 4, 2'b11);
        cyc(2);
        chk("R7 code4 src1 no high level", int'(pend[1]), 0);
        pin[1] = 1'b0; cyc(3);
        chk("R7 code4 src1 low set", int'(pend[1]), 1);
        pulse_clr(4'b0010);
        chk("R7 code4 src1 level hold", int'(pend[1]), 1);
        wr(2, 6, 2'b11);
        pin[2] = 1'b0; cyc(3);
        chk("R7 code6 src2 low set", int'(pend[2]), 1);

        cur_req = "R8";
        wr(0, 1, 2'b11);
        chk("R8 change clears", int'(pend[0]), 0);
        chk("R8 code stored", int'(sens[2:0]), 1);
        cyc(2);
        chk("R8 stays clear", int'(pend[0]), 0);

        cur_req = "R9";
        pin[0] = 1'b0; cyc(2);
        pin[0] = 1'b1; cyc(3);
        chk("R9 rise set", int'(pend[0]), 1);
        wr(0, 1, 2'b11);
        chk("R9 same value keeps flag", int'(pend[0]), 1);

        cur_req = "R10";
        wr(0, 2, 2'b10);
        chk("R10 code kept lvl2", int'(sens[2:0]), 1);
        chk("R10 flag kept lvl2", int'(pend[0]), 1);
        wr(3, 0, 2'b01);
        wr(3, 1, 2'b00);
        chk("R10 code kept lvl1/0", int'(sens[11:9]), 3);

        cur_req = "R11";
        plo[2] = 1'b1; cyc(1);
        chk("R11 mask clears", int'(pend[2]), 0);
        pulse_clr(4'b0001);
        plo[0] = 1'b1;
        pin[0] = 1'b0; cyc(2);
        pin[0] = 1'b1; cyc(3);
        chk("R11 masked level", int'(pend[2]), 0);
        plo[0] = 1'b0; cyc(2);
        chk("R11 masked edge discarded", int'(pend[0]), 0);
        plo[2] = 1'b0; cyc(1);
        chk("R11 unmask level returns", int'(pend[2]), 1);

        cur_req = "R12";
        pin[0] = 1'b0; cyc(3);
        pin[0] = 1'b1; cyc(2);
        pulse_clr(4'b0001);
        chk("R12 set wins over clear", int'(pend[0]), 1);
        pulse_clr(4'b0001);
        chk("R12 clear", int'(pend[0]), 0);

        cyc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule